// File: doc/BRIEF.md
# Endpoint-0 control and status flags

This block keeps the low control/status byte of a USB device-mode control endpoint. It holds six live flags: receive-packet ready, transmit-packet ready, stall handshake sent, stall request, last-data marker and early end of a control transfer. Software touches the byte through a simple write strobe with an 8-bit data word and reads it back at any time. A write acts on the flags bit by bit: some bits set a flag, some clear one, and some are dedicated clear triggers for other flags.

The USB transaction engine drives single-cycle event pulses into the block: a packet was received, a loaded packet was sent and acknowledged, a stall handshake went out, a control transfer ended early, and the status stage finished. In return the block drives the packet-ready, stall-request and last-packet levels back to the engine. It also drives a one-cycle pulse that sets the endpoint-0 bit of the transmit interrupt status when a control transfer is cut short.

Every flag changes on the clock edge that follows its cause. When a set cause and a clear cause for the same flag fall in the same cycle, the set cause wins. An external reset is applied asynchronously and is released in step with the clock.

Top module: `ep0_ctl_status`

## Requirements
- R1: After reset the read byte is 0x00 and every output toward the engine is 0.
- R2: The read byte is {0, 0, STALL, SETEND, DATAEND, STALLED, TXRDY, RXRDY}, from bit 7 down to bit 0. Bits 7 and 6 always read 0. Written values in bits 4 and 0 have no effect.
- R3: A packet-received pulse sets RXRDY (bit 0). A write with bit 6 = 1 clears RXRDY.
- R4: A write with bit 5 = 1 sets STALL, and a write with bit 5 = 0 leaves it unchanged. A stall-sent pulse clears STALL.
- R5: A stall-sent pulse sets STALLED (bit 2). A write with bit 2 = 0 clears STALLED, and a write with bit 2 = 1 leaves it unchanged.
- R6: A transfer-ended-early pulse while DATAEND is 0 sets SETEND (bit 4) and gives a one-cycle interrupt pulse in the cycle after the event. The same pulse while DATAEND is 1 has no effect. A write with bit 7 = 1 clears SETEND.
- R7: A write with bit 3 = 1 sets DATAEND, and a write with bit 3 = 0 leaves it unchanged. A packet-sent pulse or a status-stage-done pulse clears DATAEND.
- R8: A write with bit 1 = 1 sets TXRDY, and a write with bit 1 = 0 leaves it unchanged. A packet-sent pulse clears TXRDY.
- R9: If a flag is set and cleared in the same cycle, the flag ends up set. This holds for every flag, whichever side (software or hardware) sets it.
- R10: Each flag change is visible on the read byte and on the engine outputs one clock after its cause. rx_ready, tx_ready, stall_req and last_pkt equal bits 0, 1, 5 and 3 of the read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 8 | Software write data |
| reg_rdata | output | 8 | Live read value of the byte |
| ev_rx_pkt | input | 1 | Pulse: packet fully received into endpoint 0 |
| ev_tx_done | input | 1 | Pulse: loaded packet sent and acknowledged |
| ev_stall_sent | input | 1 | Pulse: stall handshake transmitted |
| ev_ctrl_abort | input | 1 | Pulse: control transfer ended early |
| ev_stage_done | input | 1 | Pulse: status stage completed |
| rx_ready | output | 1 | Received packet waiting for software |
| tx_ready | output | 1 | Packet loaded and ready to send |
| stall_req | output | 1 | Answer the next transaction with a stall |
| last_pkt | output | 1 | Current packet is the last of the data phase |
| ep0_int | output | 1 | One-cycle pulse setting the endpoint-0 transmit interrupt bit |

## Verification
The main function is first tried with single causes, one flag at a time. These cases show that each write bit and each event pulse reaches only its own flag, and that the write bits with no effect and the trigger bits change nothing else. Paired causes in one cycle follow: software clear against hardware set, and hardware clear against software set. They separate a set-wins rule from a clear-wins rule for every flag. The early-end pulse is given both with and without DATAEND set, which shows the condition on SETEND and on the interrupt. A long run of sparse random writes and events, compared against a behavioural model on every clock, mixes all of these cases.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int REG_W      = 8;
  localparam int NFLAG      = 6;
  // bit positions inside the byte (software decodes these)
  localparam int B_SETENDC  = 7;
  localparam int B_RXRDYC   = 6;
  localparam int B_STALL    = 5;
  localparam int B_SETEND   = 4;
  localparam int B_DATAEND  = 3;
  localparam int B_STALLED  = 2;
  localparam int B_TXRDY    = 1;
  localparam int B_RXRDY    = 0;
endpackage

// File: rtl/ep0_rst_sync.sv
module ep0_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ep0_wr_decode.sv
module ep0_wr_decode
  import ep0_pkg::*;
(
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             ev_rx_pkt,
  input  logic             ev_tx_done,
  input  logic             ev_stall_sent,
  input  logic             ev_ctrl_abort,
  input  logic             ev_stage_done,
  input  logic             dataend_q,
  output logic [NFLAG-1:0] set_v,
  output logic [NFLAG-1:0] clr_v,
  output logic             int_set
);
  logic abort_early;

  always_comb begin
    abort_early = ev_ctrl_abort & ~dataend_q;

    set_v = '0;
    set_v[B_RXRDY]   = ev_rx_pkt;
    set_v[B_TXRDY]   = reg_wr & reg_wdata[B_TXRDY];
    set_v[B_STALLED] = ev_stall_sent;
    set_v[B_DATAEND] = reg_wr & reg_wdata[B_DATAEND];
    set_v[B_SETEND]  = abort_early;
    set_v[B_STALL]   = reg_wr & reg_wdata[B_STALL];

    clr_v = '0;
    clr_v[B_RXRDY]   = reg_wr & reg_wdata[B_RXRDYC];
    clr_v[B_TXRDY]   = ev_tx_done;
    clr_v[B_STALLED] = reg_wr & ~reg_wdata[B_STALLED];
    clr_v[B_DATAEND] = ev_tx_done | ev_stage_done;
    clr_v[B_SETEND]  = reg_wr & reg_wdata[B_SETENDC];
    clr_v[B_STALL]   = ev_stall_sent;

    int_set = abort_early;
  end
endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt;
    logic en;

    always_comb begin
      en  = set_v[i] | clr_v[i];
      nxt = set_v[i];          // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[i] <= 1'b0;
      else if (en) flag_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
  import ep0_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_rx_pkt,
  input  logic             ev_tx_done,
  input  logic             ev_stall_sent,
  input  logic             ev_ctrl_abort,
  input  logic             ev_stage_done,
  output logic             rx_ready,
  output logic             tx_ready,
  output logic             stall_req,
  output logic             last_pkt,
  output logic             ep0_int
);
  logic             rst_n_i;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag_q;
  logic             int_set;
  logic             int_q;
  logic             int_d;

  ep0_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ep0_wr_decode u_dec (
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .ev_rx_pkt     (ev_rx_pkt),
    .ev_tx_done    (ev_tx_done),
    .ev_stall_sent (ev_stall_sent),
    .ev_ctrl_abort (ev_ctrl_abort),
    .ev_stage_done (ev_stage_done),
    .dataend_q     (flag_q[B_DATAEND]),
    .set_v         (set_v),
    .clr_v         (clr_v),
    .int_set       (int_set)
  );

  ep0_flag_bank #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .set_v  (set_v),
    .clr_v  (clr_v),
    .flag_q (flag_q)
  );

  always_comb begin
    int_d = int_set;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) int_q <= 1'b0;
    else          int_q <= int_d;
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[NFLAG-1:0] = flag_q;
  end

  assign rx_ready  = flag_q[B_RXRDY];
  assign tx_ready  = flag_q[B_TXRDY];
  assign stall_req = flag_q[B_STALL];
  assign last_pkt  = flag_q[B_DATAEND];
  assign ep0_int   = int_q;
endmodule

// File: rtl/ep0_ctl_status_chk.sv
module ep0_ctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       ev_rx_pkt,
  input logic       ev_tx_done,
  input logic       ev_stall_sent,
  input logic       ev_ctrl_abort,
  input logic       ev_stage_done,
  input logic       rx_ready,
  input logic       tx_ready,
  input logic       stall_req,
  input logic       last_pkt,
  input logic       ep0_int
);
  AST_TRIGGER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:6] == 2'b00); // R2

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> rx_ready); // R3

  AST_STALL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall_sent && !(reg_wr && reg_wdata[5])) |=> !stall_req); // R4

  AST_STALLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall_sent |=> reg_rdata[2]); // R5

  AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ep0_int |-> ($past(ev_ctrl_abort) && !$past(last_pkt))); // R6

  AST_SETEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_ctrl_abort && !(reg_wr && reg_wdata[7])) |=> $stable(reg_rdata[4])); // R6

  AST_DATAEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_tx_done || ev_stage_done) && !(reg_wr && reg_wdata[3])) |=> !last_pkt); // R7

  AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && !(reg_wr && reg_wdata[1])) |=> !tx_ready); // R8
endmodule

bind ep0_ctl_status ep0_ctl_status_chk u_chk (.*);

// File: tb/ep0_ctl_status_tb.sv
`timescale 1ns/1ps
module ep0_ctl_status_tb;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ev_rx_pkt, ev_tx_done, ev_stall_sent, ev_ctrl_abort, ev_stage_done;
  logic       rx_ready, tx_ready, stall_req, last_pkt, ep0_int;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_rx, m_tx, m_stalled, m_de, m_se, m_st, m_int;

  ep0_ctl_status u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done),
    .ev_stall_sent(ev_stall_sent), .ev_ctrl_abort(ev_ctrl_abort),
    .ev_stage_done(ev_stage_done), .rx_ready(rx_ready), .tx_ready(tx_ready),
    .stall_req(stall_req), .last_pkt(last_pkt), .ep0_int(ep0_int)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // model update: set beats clear (R9), one clock of latency (R10)
  always @(posedge clk) begin
    bit wr;
    bit [7:0] d;
    bit n_rx, n_tx, n_stalled, n_de, n_se, n_st, n_int;
    wr = reg_wr;
    d  = reg_wdata;
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_stalled = 0; m_de = 0; m_se = 0; m_st = 0; m_int = 0;
    end else begin
      n_rx = ev_rx_pkt ? 1'b1 : ((wr && d[6]) ? 1'b0 : m_rx);
      n_tx = (wr && d[1]) ? 1'b1 : (ev_tx_done ? 1'b0 : m_tx);
      n_stalled = ev_stall_sent ? 1'b1 : ((wr && !d[2]) ? 1'b0 : m_stalled);
      n_de = (wr && d[3]) ? 1'b1 : ((ev_tx_done || ev_stage_done) ? 1'b0 : m_de);
      n_se = (ev_ctrl_abort && !m_de) ? 1'b1 : ((wr && d[7]) ? 1'b0 : m_se);
      n_st = (wr && d[5]) ? 1'b1 : (ev_stall_sent ? 1'b0 : m_st);
      n_int = ev_ctrl_abort && !m_de;
      m_rx = n_rx; m_tx = n_tx; m_stalled = n_stalled;
      m_de = n_de; m_se = n_se; m_st = n_st; m_int = n_int;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 trigger bits read zero", {6'b0, reg_rdata[7:6]}, 8'h00);
    chk("R3 RXRDY", {7'b0, reg_rdata[0]}, {7'b0, m_rx});
    chk("R8 TXRDY", {7'b0, reg_rdata[1]}, {7'b0, m_tx});
    chk("R5 STALLED", {7'b0, reg_rdata[2]}, {7'b0, m_stalled});
    chk("R7 DATAEND", {7'b0, reg_rdata[3]}, {7'b0, m_de});
    chk("R6 SETEND", {7'b0, reg_rdata[4]}, {7'b0, m_se});
    chk("R4 STALL", {7'b0, reg_rdata[5]}, {7'b0, m_st});
    chk("R6 interrupt pulse", {7'b0, ep0_int}, {7'b0, m_int});
    chk("R10 engine outputs", {4'b0, last_pkt, stall_req, tx_ready, rx_ready},
        {4'b0, m_de, m_st, m_tx, m_rx});
  endtask

  // compare the state left by the previous cycle, then drive the next one
  task automatic tick(input bit wr, input logic [7:0] wd, input bit rx, input bit tx,
                      input bit ss, input bit ab, input bit sd);
    @(negedge clk);
    compare_all();
    reg_wr = wr; reg_wdata = wd; ev_rx_pkt = rx; ev_tx_done = tx;
    ev_stall_sent = ss; ev_ctrl_abort = ab; ev_stage_done = sd;
  endtask

  task automatic idle();
    tick(0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_byte(input logic [7:0] wd);
    tick(1, wd, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_wdata = 0; ev_rx_pkt = 0; ev_tx_done = 0;
    ev_stall_sent = 0; ev_ctrl_abort = 0; ev_stage_done = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset byte", reg_rdata, 8'h00);
    chk("R1 reset outputs", {3'b0, rx_ready, tx_ready, stall_req, last_pkt, ep0_int}, 8'h00);
    rst_n = 1'b1;
    repeat (4) idle();

    // R3 / R2: receive, ignored bits, clear trigger
    tick(0, 8'h00, 1, 0, 0, 0, 0); idle();
    wr_byte(8'h01); idle();          // bit0 ignored
    wr_byte(8'h14); idle();          // bit4 ignored, bit2=1 keeps STALLED
    wr_byte(8'h40); idle();          // clears RXRDY
    // R9: receive and clear in the same cycle
    tick(1, 8'h40, 1, 0, 0, 0, 0); idle();
    wr_byte(8'h40); idle();

    // R8 / R7: load and send packets
    wr_byte(8'h02); idle();
    wr_byte(8'h00); idle();          // bit1=0 does not cancel
    tick(0, 8'h00, 0, 1, 0, 0, 0); idle();
    wr_byte(8'h0A); idle();          // last packet
    tick(0, 8'h00, 0, 1, 0, 0, 0); idle();
    wr_byte(8'h08); idle();
    tick(0, 8'h00, 0, 0, 0, 0, 1); idle();
    // R9: hardware clear against software set
    wr_byte(8'h02); tick(1, 8'h0A, 0, 1, 0, 0, 0); idle();

    // R4 / R5: stall
    wr_byte(8'h20); idle();
    wr_byte(8'h04); idle();          // bit5=0: STALL unchanged
    tick(0, 8'h00, 0, 0, 1, 0, 0); idle();
    wr_byte(8'h04); idle();          // STALLED kept
    wr_byte(8'h00); idle();          // STALLED cleared
    // R9: stall sent together with software clear of STALLED and new stall request
    wr_byte(8'h20); tick(1, 8'h20, 0, 0, 1, 0, 0); idle();
    tick(0, 8'h00, 0, 0, 1, 0, 0); idle();

    // R6: early end
    tick(0, 8'h00, 0, 1, 0, 0, 1); idle();  // DATAEND low
    tick(0, 8'h00, 0, 0, 0, 1, 0); idle();
    wr_byte(8'h10); idle();          // bit4 write ignored
    wr_byte(8'h80); idle();
    wr_byte(8'h08); idle();
    tick(0, 8'h00, 0, 0, 0, 1, 0); idle();  // ignored: DATAEND set
    tick(0, 8'h00, 0, 0, 0, 0, 1); idle();
    tick(1, 8'h80, 0, 0, 0, 1, 0); idle();  // R9 set wins
    wr_byte(8'h80); idle();

    // mixed sparse random traffic
    for (int i = 0; i < 400; i++) begin
      bit wr;
      logic [7:0] wd;
      wr = ($urandom_range(0, 3) == 0);
      wd = 8'($urandom);
      tick(wr, wd, ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 6) == 0), ($urandom_range(0, 6) == 0),
           ($urandom_range(0, 7) == 0));
    end
    idle(); idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule